// File: doc/BRIEF.md
# Shared Multiply Issue Controller

This block decides when operations may enter a multiply pipeline that two number formats share, and it tracks them until their results appear. Each request carries a one-bit format tag. Binary operations flow through a fixed-depth pipeline, one per cycle, and each finishes after a fixed number of cycles. A decimal operation takes the whole unit for itself. The datapath reports during the first pass whether the decimal result needs rounding. A decimal operation that needs no rounding finishes after the same number of cycles as a binary one. One that needs rounding has the controller steer the datapath into a feedback pass, and it finishes ten cycles later.

The issuing side holds a request until `req_ready` is high, and the request is taken in that cycle. A decimal request may not join binary work that is still in flight. A drain counter is reloaded on every binary issue and counts down to zero, and the decimal request waits until it reaches zero. Each operation that issues produces one `res_valid` pulse with its format tag, and the pulses follow issue order.

Top module: `mulctl_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` and `fb_sel` are low and `req_ready` is high.
- R2: With no decimal operation in flight, a binary request (`req_fmt`=0) is accepted in the cycle it is presented, and back-to-back binary requests are accepted one per cycle.
- R3: A binary operation accepted in cycle c gives `res_valid`=1 with `res_fmt`=0 in cycle c+5.
- R4: A decimal request (`req_fmt`=1) presented when the unit is idle and the last binary accept is more than 5 cycles in the past is accepted in the same cycle.
- R5: A decimal request presented while binary operations are in flight is held with `req_ready`=0 until the cycle after the last binary result, and it is accepted in that cycle.
- R6: While a decimal operation is in flight, `req_ready` is low for both formats. It goes high again in the cycle of that operation's result.
- R7: For a decimal operation accepted in cycle c, `rnd_need` is sampled only in cycle c+3. Its value in every other cycle has no effect on the result timing or on `fb_sel`.
- R8: A decimal operation accepted in cycle c whose sample is 0 gives `res_valid`=1 with `res_fmt`=1 in cycle c+5, and `fb_sel` stays low.
- R9: A decimal operation accepted in cycle c whose sample is 1 holds `fb_sel` high in cycles c+5 through c+14 and gives `res_valid`=1 with `res_fmt`=1 in cycle c+15.
- R10: Every accepted operation gives exactly one `res_valid` pulse. No pulse appears in any other cycle.
- R11: Reset asserted in the middle of operations discards all of them at once. No result from them appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_fmt | input | 1 | Request format: 0 binary, 1 decimal |
| rnd_need | input | 1 | Rounding-needed indication from the datapath |
| req_ready | output | 1 | Request accepted this cycle when req_valid is high |
| fb_sel | output | 1 | Selects the rounding feedback pass in the datapath |
| res_valid | output | 1 | One-cycle result pulse |
| res_fmt | output | 1 | Format tag of the result: 0 binary, 1 decimal |

## Verification
The assertions assume that the issuing side keeps a request steady until it is accepted. They also assume that `rnd_need` is meaningful only in the sample cycle of a decimal operation. The stimulus presents each request and holds it until the bench's own timing model predicts acceptance. In every cycle other than the sample cycle, it drives `rnd_need` to the opposite of the value that will be sampled. A controller that reads the indication in the wrong cycle therefore moves the decimal result and the feedback window away from where they are expected.

// File: rtl/mulctl_pkg.sv
package mulctl_pkg;
  typedef enum logic {
    FMT_BIN = 1'b0,
    FMT_DEC = 1'b1
  } fmt_e;
endpackage

// File: rtl/mulctl_bin_track.sv
// Tracks binary operations in flight: a delay line that marks when each
// result emerges, and a drain counter that reaches zero once all have left.
module mulctl_bin_track #(
  parameter int LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic done,
  output logic drain_zero
);
  localparam int CW = $clog2(LAT + 1);

  logic [LAT-1:0] pipe_q, pipe_d;
  logic [CW-1:0]  drain_q, drain_d;
  logic           drain_en;

  always_comb begin
    pipe_d   = {pipe_q[LAT-2:0], issue};
    drain_en = issue || (drain_q != '0);
    if (issue) drain_d = CW'(LAT);
    else       drain_d = drain_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        drain_q <= '0;
    else if (drain_en) drain_q <= drain_d;
  end

  assign done       = pipe_q[LAT-1];
  assign drain_zero = (drain_q == '0);
endmodule

// File: rtl/mulctl_dec_seq.sv
// Sequences one exclusive decimal operation: short pass, or a longer pass
// with rounding feedback chosen by a single sample of rnd_need.
module mulctl_dec_seq #(
  parameter int SHORT  = 5,
  parameter int LONG   = 15,
  parameter int RND_AT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic rnd_need,
  output logic hold,
  output logic done,
  output logic fb_sel
);
  localparam int PW = $clog2(LONG + 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          rnd_q, rnd_d;
  logic          active;

  always_comb begin
    active = (phase_q != '0);
    done   = active && ((phase_q == PW'(SHORT) && !rnd_q) ||
                        (phase_q == PW'(LONG)  &&  rnd_q));
    hold   = active && !done;
    fb_sel = rnd_q && (phase_q >= PW'(SHORT)) && (phase_q < PW'(LONG));

    if (issue)     phase_d = PW'(1);
    else if (hold) phase_d = phase_q + 1'b1;
    else           phase_d = '0;

    if (issue)                         rnd_d = 1'b0;
    else if (phase_q == PW'(RND_AT))   rnd_d = rnd_need;
    else if (!active)                  rnd_d = 1'b0;
    else                               rnd_d = rnd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      rnd_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rnd_q   <= rnd_d;
    end
  end
endmodule

// File: rtl/mulctl_issue.sv
// Admission decision for the single request port.
module mulctl_issue
  import mulctl_pkg::*;
(
  input  logic req_valid,
  input  logic req_fmt,
  input  logic dec_hold,
  input  logic drain_zero,
  output logic req_ready,
  output logic bin_issue,
  output logic dec_issue
);
  fmt_e fmt;

  always_comb begin
    fmt       = fmt_e'(req_fmt);
    req_ready = !dec_hold && ((fmt == FMT_BIN) || drain_zero);
    bin_issue = req_valid && req_ready && (fmt == FMT_BIN);
    dec_issue = req_valid && req_ready && (fmt == FMT_DEC);
  end
endmodule

// File: rtl/mulctl_top.sv
module mulctl_top
  import mulctl_pkg::*;
#(
  parameter int BIN_LAT   = 5,
  parameter int DEC_SHORT = 5,
  parameter int DEC_LONG  = 15,
  parameter int RND_AT    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_fmt,
  input  logic rnd_need,
  output logic req_ready,
  output logic fb_sel,
  output logic res_valid,
  output logic res_fmt
);
  logic bin_issue, dec_issue;
  logic bin_done, dec_done;
  logic dec_hold, drain_zero;

  mulctl_issue u_issue (
    .req_valid  (req_valid),
    .req_fmt    (req_fmt),
    .dec_hold   (dec_hold),
    .drain_zero (drain_zero),
    .req_ready  (req_ready),
    .bin_issue  (bin_issue),
    .dec_issue  (dec_issue)
  );

  mulctl_bin_track #(.LAT(BIN_LAT)) u_bin (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (bin_issue),
    .done       (bin_done),
    .drain_zero (drain_zero)
  );

  mulctl_dec_seq #(.SHORT(DEC_SHORT), .LONG(DEC_LONG), .RND_AT(RND_AT)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (dec_issue),
    .rnd_need (rnd_need),
    .hold     (dec_hold),
    .done     (dec_done),
    .fb_sel   (fb_sel)
  );

  always_comb begin
    res_valid = bin_done || dec_done;
    res_fmt   = dec_done ? logic'(FMT_DEC) : logic'(FMT_BIN);
  end
endmodule

// File: rtl/mulctl_chk.sv
module mulctl_chk #(
  parameter int BIN_LAT = 5
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_fmt,
  input logic req_ready,
  input logic fb_sel,
  input logic res_valid,
  input logic res_fmt,
  input logic dec_hold,
  input logic drain_zero
);
  logic [BIN_LAT-1:0] bin_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bin_seen_q <= '0;
    else        bin_seen_q <= {bin_seen_q[BIN_LAT-2:0], req_valid && req_ready && !req_fmt};
  end

  // R5
  dec_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_fmt) |-> drain_zero);

  // R6
  dec_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hold |-> !req_ready);

  // R3
  bin_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_seen_q[BIN_LAT-1] |-> (res_valid && !res_fmt));

  // R9
  fb_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fb_sel) |-> (res_valid && res_fmt));

  // R9
  fb_within_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_sel |-> dec_hold);

  // R10
  dec_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fmt) |=> !(res_valid && res_fmt));
endmodule

bind mulctl_top mulctl_chk #(.BIN_LAT(BIN_LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_fmt    (req_fmt),
  .req_ready  (req_ready),
  .fb_sel     (fb_sel),
  .res_valid  (res_valid),
  .res_fmt    (res_fmt),
  .dec_hold   (dec_hold),
  .drain_zero (drain_zero)
);

// File: tb/mulctl_top_test.sv
module mulctl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int BLAT  = 5;
  localparam int DSHRT = 5;
  localparam int DLONG = 15;
  localparam int RAT   = 3;
  localparam int MAXC  = 1024;
  localparam int NOPS  = 14;

  // entry: {idle[3:0], fmt, rnd}
  localparam logic [5:0] OPS [0:NOPS-1] = '{
    {4'd0, 1'b0, 1'b0},
    {4'd0, 1'b0, 1'b0},
    {4'd0, 1'b0, 1'b0},
    {4'd0, 1'b1, 1'b0},
    {4'd0, 1'b0, 1'b0},
    {4'd0, 1'b1, 1'b1},
    {4'd0, 1'b1, 1'b0},
    {4'd2, 1'b0, 1'b0},
    {4'd0, 1'b0, 1'b0},
    {4'd3, 1'b1, 1'b1},
    {4'd0, 1'b0, 1'b0},
    {4'd0, 1'b0, 1'b0},
    {4'd6, 1'b1, 1'b0},
    {4'd0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, req_valid, req_fmt, rnd_need;
  logic req_ready, fb_sel, res_valid, res_fmt;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int dec_free = 0;
  int last_bin = -100;
  int rnd_at = -1;
  logic rnd_v = 1'b0;
  int issued = 0;
  int pulses = 0;
  logic exp_v [0:MAXC-1];
  logic exp_f [0:MAXC-1];
  logic exp_r [0:MAXC-1];
  logic exp_fb[0:MAXC-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  mulctl_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fmt(req_fmt),
    .rnd_need(rnd_need), .req_ready(req_ready), .fb_sel(fb_sel),
    .res_valid(res_valid), .res_fmt(res_fmt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < MAXC; k++) begin
      exp_v[k] = 1'b0; exp_f[k] = 1'b0; exp_r[k] = 1'b0; exp_fb[k] = 1'b0;
    end
    dec_free = cyc; last_bin = -100; rnd_at = -1;
  endtask

  task automatic check_outputs();
    string tag;
    if (cyc >= MAXC) return;
    if (exp_v[cyc]) tag = exp_f[cyc] ? (exp_r[cyc] ? "R7 R9 rounded decimal result" : "R7 R8 decimal result") : "R3 binary result";
    else            tag = "R10 no stray result";
    check(res_valid === exp_v[cyc], tag, int'(res_valid), int'(exp_v[cyc]));
    if (exp_v[cyc] && res_valid === 1'b1)
      check(res_fmt === exp_f[cyc], "R3 R8 R9 format tag", int'(res_fmt), int'(exp_f[cyc]));
    check(fb_sel === exp_fb[cyc], "R7 R9 feedback select", int'(fb_sel), int'(exp_fb[cyc]));
    if (res_valid === 1'b1) pulses++;
  endtask

  task automatic step(input logic v, input logic f, input logic r, output logic acc);
    logic pred;
    string tag;
    req_valid = v;
    req_fmt   = f;
    rnd_need  = (cyc == rnd_at) ? rnd_v : ~rnd_v;
    @(negedge clk);
    check_outputs();
    acc = 1'b0;
    if (v) begin
      pred = (cyc >= dec_free) && (!f || cyc > last_bin + BLAT);
      if (cyc < dec_free) tag = "R6 held during decimal";
      else if (!f)        tag = "R2 binary accept";
      else if (pred)      tag = "R4 R5 decimal accept";
      else                tag = "R5 decimal waits for drain";
      check(req_ready === pred, tag, int'(req_ready), int'(pred));
      if (pred) begin
        acc = 1'b1;
        issued++;
        if (!f) begin
          exp_v[cyc+BLAT] = 1'b1; exp_f[cyc+BLAT] = 1'b0;
          last_bin = cyc;
        end else begin
          int lat;
          lat = r ? DLONG : DSHRT;
          exp_v[cyc+lat] = 1'b1; exp_f[cyc+lat] = 1'b1; exp_r[cyc+lat] = r;
          if (r) for (int k = DSHRT; k < DLONG; k++) exp_fb[cyc+k] = 1'b1;
          dec_free = cyc + lat;
          rnd_at = cyc + RAT;
          rnd_v = r;
        end
      end
    end
    @(posedge clk); #1;
    cyc++;
  endtask

  task automatic run_op(input logic f, input logic r);
    logic acc;
    acc = 1'b0;
    while (!acc) step(1'b1, f, r, acc);
  endtask

  task automatic idle(input int n);
    logic acc;
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, acc);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired R10");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_fmt = 1'b0; rnd_need = 1'b0;
    clear_model();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(res_valid === 1'b0, "R1 reset res_valid", int'(res_valid), 0);
    check(fb_sel === 1'b0, "R1 reset fb_sel", int'(fb_sel), 0);
    check(req_ready === 1'b1, "R1 reset req_ready", int'(req_ready), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cyc = 0;
    clear_model();
    @(negedge clk);
    check(res_valid === 1'b0 && fb_sel === 1'b0 && req_ready === 1'b1,
          "R1 first cycle after reset", int'({req_ready, fb_sel, res_valid}), 4);
    @(posedge clk); #1;
    cyc = 1;
    dec_free = 1;

    for (int i = 0; i < NOPS; i++) begin
      idle(int'(OPS[i][5:2]));
      run_op(OPS[i][1], OPS[i][0]);
    end
    idle(DLONG + 4);
    check(pulses == issued, "R10 one pulse per operation", pulses, issued);

    // R11: reset while a rounded decimal is in its feedback pass
    run_op(1'b1, 1'b1);
    idle(8);
    rst_n = 1'b0;
    #1;
    check(fb_sel === 1'b0, "R11 fb_sel cleared by reset", int'(fb_sel), 0);
    check(req_ready === 1'b1, "R11 ready after reset", int'(req_ready), 1);
    check(res_valid === 1'b0, "R11 res_valid cleared by reset", int'(res_valid), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    cyc++;
    clear_model();
    idle(DLONG + 3);

    // R11: reset with binaries in flight, then a decimal must issue at once
    run_op(1'b0, 1'b0);
    run_op(1'b0, 1'b0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    cyc++;
    clear_model();
    idle(2);
    run_op(1'b1, 1'b0);
    check(cyc - 1 == dec_free - DSHRT, "R11 decimal issues without drain after reset",
          cyc - 1, dec_free - DSHRT);
    idle(DLONG);
    finish_run();
  end
endmodule